// File: doc/BRIEF.md
# ROM Read Sequencer

This block runs read transactions against external ROM or flash devices for an internal requester. Each memory space has its own configuration word, which gives the first-beat wait, the wait for later beats, a bus-release delay and a device kind (burst-capable or not). The requester raises a request carrying a space number, a word address and a burst-length code. The block then drives one active-low select per space, a shared active-low output enable and the word address. It captures the data bus once at the end of every beat and returns each word with a one-cycle strobe. A completion pulse follows the final word.

Between beats of a multi-word transaction, a refresh request from a DRAM controller can take one idle cycle, during which select and output enable are released. When the next access targets a different space, the block holds it off until the previous device has released the bus. An access to the same space goes ahead without that wait. Space 0 is the boot space: its timing fields come out of reset at their slowest values, and its width bit comes from a strap pin.

Top module: `rom_read_ctrl`

## Requirements
- R1: Under reset, space 0 loads first-beat wait 31, later-beat wait 31, release delay 7, non-burst kind, and a width bit equal to the inverse of `rom_sel`. Once reset is released, all selects and `oe_n` are high, `rd_valid` is low and `req_ready` is high.
- R2: A request is accepted at the clock edge where `req_valid` and `req_ready` are both high. Select and `oe_n` go low in the cycle after that edge. The data bus is captured at the (first+1)-th edge after acceptance, and `rd_valid` is high with that word on `rd_data` during the following cycle.
- R3: For a non-burst device (kind bit 0), every beat lasts first+1 cycles, and the later-beat field has no effect.
- R4: For a burst device (kind bit 1), the first beat lasts first+1 cycles and each later beat lasts later+1 cycles.
- R5: Length code 0 reads 1 word, 1 reads 4 words, 2 reads 8 words and 3 reads 1 word. For 8 words, address bits [2:0] carry the beat index 0..7. For 4 words, bits [1:0] carry it. All other address bits stay at the requested value for the whole transaction.
- R6: Exactly the select of the accessed space is low, together with `oe_n`, from the cycle after acceptance until the edge that captures the last word. At that edge both are released.
- R7: `done` pulses for one cycle, in the cycle right after the final `rd_valid`.
- R8: If `refresh_req` is high at the edge that captures a word and more words remain, one cycle is inserted with every select and `oe_n` high and `refresh_ack` high. The next beat then starts. This happens at most once per transaction and never on single-word reads.
- R9: A request to a different space than the last access is accepted no earlier than D edges after the last word was captured. D is 2×delay, or 1 when the delay field is 0. `req_ready` stays low until then.
- R10: A request to the same space as the last access can be accepted at the first edge after the last word was captured.
- R11: A configuration word has first wait in bits [4:0], later wait in [9:5], release delay in [12:10], kind in [13] and width in [14]. It is written to the space `cfg_space` when `cfg_we` is high. An access uses the word held at its acceptance, so writes during the access do not affect it. `acc_wide` shows that word's width bit from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_sel | input | 1 | Boot width strap, sampled during reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_space | input | SW | Space whose configuration is written |
| cfg_wdata | input | 15 | Configuration word |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_space | input | SW | Target memory space |
| req_addr | input | AW | Word address |
| req_len | input | 2 | Burst length code |
| mem_data | input | DW | External data bus |
| refresh_req | input | 1 | Refresh slot wanted by DRAM controller |
| cs_n | output | NSP | Active-low select per space |
| oe_n | output | 1 | Active-low output enable |
| mem_addr | output | AW | External word address |
| rd_valid | output | 1 | Returned word strobe |
| rd_data | output | DW | Returned word |
| done | output | 1 | Transaction complete pulse |
| refresh_ack | output | 1 | Refresh cycle in progress |
| acc_wide | output | 1 | Width bit of the current access |

## Verification
The bench measures every result from the acceptance edge. Word k is due (first+1) cycles after acceptance for k=0. Each later word follows after (first or later)+1 further cycles, plus one extra cycle for an inserted refresh. `done` is due one cycle after the last word, and the next acceptance is due D cycles (or 1 for the same space) after the last word. The driver works these cycle numbers out from its own shadow of the configuration and queues them. The monitor samples one nanosecond after each falling edge against a free-running edge counter, so a word that arrives one cycle early or late fails, just as wrong data does. Select, enable and refresh strobes are compared every cycle against the window the driver computed.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  localparam int FIRST_W = 5;
  localparam int NEXT_W  = 5;
  localparam int TURN_W  = 3;
  localparam int CNT_W   = (FIRST_W > NEXT_W) ? FIRST_W : NEXT_W;

  typedef struct packed {
    logic              wide;
    logic              burst;
    logic [TURN_W-1:0] turn;
    logic [NEXT_W-1:0] nxt;
    logic [FIRST_W-1:0] first;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_REFR} st_e;

  localparam logic [1:0] LEN_1 = 2'd0;
  localparam logic [1:0] LEN_4 = 2'd1;
  localparam logic [1:0] LEN_8 = 2'd2;

  function automatic logic [2:0] last_index(input logic [1:0] len);
    case (len)
      LEN_8:   return 3'd7;
      LEN_4:   return 3'd3;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rom_cfg_bank.sv
module rom_cfg_bank
  import rom_rd_pkg::*;
#(
  parameter int NSP = 2,
  parameter int SW  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rom_sel,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  cfg_t          wdata,
  input  logic [SW-1:0] rsel,
  output cfg_t          rcfg
);
  cfg_t cfg_q [NSP];

  for (genvar g = 0; g < NSP; g++) begin : g_space
    if (g == 0) begin : g_boot
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_q[g].wide  <= ~rom_sel;
          cfg_q[g].burst <= 1'b0;
          cfg_q[g].turn  <= '1;
          cfg_q[g].nxt   <= '1;
          cfg_q[g].first <= '1;
        end else if (we && wsel == SW'(g)) begin
          cfg_q[g] <= wdata;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (we && wsel == SW'(g)) cfg_q[g] <= wdata;
      end
    end
  end

  assign rcfg = cfg_q[rsel];

  // boot space comes out of reset at its slowest timing
  assert_boot_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q[0].first == '1 && cfg_q[0].nxt == '1 &&
                    cfg_q[0].turn == '1 && !cfg_q[0].burst &&
                    cfg_q[0].wide != $past(rom_sel)));
endmodule

// File: rtl/rom_turn_timer.sv
module rom_turn_timer
  import rom_rd_pkg::*;
#(
  parameter int SW = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic [SW-1:0]     fin_space,
  input  logic [TURN_W-1:0] fin_turn,
  input  logic              start,
  input  logic [SW-1:0]     req_space,
  output logic              space_ok
);
  localparam int TC_W = TURN_W + 1;

  logic [TC_W-1:0] cnt_q;
  logic [SW-1:0]   last_q;
  logic            have_q;
  logic [TC_W-1:0] wait_m1;

  // delay of 2*field (or 1 when zero), less the cycle spent leaving the access
  assign wait_m1 = (fin_turn == '0) ? '0 : ({fin_turn, 1'b0} - TC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= '0;
      have_q <= 1'b0;
    end else if (fin) begin
      cnt_q  <= wait_m1;
      last_q <= fin_space;
      have_q <= 1'b1;
    end else if (start) begin
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - TC_W'(1);
    end
  end

  assign space_ok = (cnt_q == '0) || (have_q && req_space == last_q);

  assert_turn_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (start && cnt_q != '0) |-> (have_q && req_space == last_q));
endmodule

// File: rtl/rom_beat_engine.sv
module rom_beat_engine
  import rom_rd_pkg::*;
#(
  parameter int NSP = 2,
  parameter int SW  = 1,
  parameter int AW  = 24,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  cfg_t              cfg_i,
  input  logic [SW-1:0]     space_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        len_i,
  input  logic [DW-1:0]     mem_data,
  input  logic              refresh_req,
  output logic              busy,
  output logic              fin,
  output logic [SW-1:0]     fin_space,
  output logic [TURN_W-1:0] fin_turn,
  output logic [NSP-1:0]    cs_n,
  output logic              oe_n,
  output logic [AW-1:0]     mem_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              refresh_ack,
  output logic              acc_wide
);
  localparam logic [NSP-1:0] SEL_ONE = NSP'(1);

  st_e             st;
  cfg_t            cur;
  logic [SW-1:0]   sp_q;
  logic [AW-1:0]   base_q;
  logic [1:0]      len_q;
  logic [2:0]      beat_q;
  logic [2:0]      last_q;
  logic [CNT_W-1:0] cnt_q;
  logic            refr_used_q;
  logic            rd_last_q;

  logic            beat_end;
  logic [CNT_W-1:0] next_lat;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                               input logic [1:0] len,
                                               input logic [2:0] idx);
    logic [AW-1:0] a;
    a = base;
    case (len)
      LEN_8:   a[2:0] = idx;
      LEN_4:   a[1:0] = idx[1:0];
      default: ;
    endcase
    return a;
  endfunction

  assign beat_end  = (st == ST_BEAT) && (cnt_q == '0);
  assign fin       = beat_end && (beat_q == last_q);
  assign next_lat  = cur.burst ? CNT_W'(cur.nxt) : CNT_W'(cur.first);
  assign busy      = (st != ST_IDLE);
  assign fin_space = sp_q;
  assign fin_turn  = cur.turn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cur         <= '0;
      sp_q        <= '0;
      base_q      <= '0;
      len_q       <= LEN_1;
      beat_q      <= '0;
      last_q      <= '0;
      cnt_q       <= '0;
      refr_used_q <= 1'b0;
      rd_last_q   <= 1'b0;
      cs_n        <= '1;
      oe_n        <= 1'b1;
      mem_addr    <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      done        <= 1'b0;
      refresh_ack <= 1'b0;
      acc_wide    <= 1'b0;
    end else begin
      rd_valid    <= 1'b0;
      refresh_ack <= 1'b0;
      done        <= rd_valid && rd_last_q;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cur         <= cfg_i;
            sp_q        <= space_i;
            base_q      <= addr_i;
            len_q       <= len_i;
            last_q      <= last_index(len_i);
            beat_q      <= '0;
            cnt_q       <= CNT_W'(cfg_i.first);
            refr_used_q <= 1'b0;
            cs_n        <= ~(SEL_ONE << space_i);
            oe_n        <= 1'b0;
            mem_addr    <= beat_addr(addr_i, len_i, 3'd0);
            acc_wide    <= cfg_i.wide;
            st          <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (!beat_end) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            rd_valid  <= 1'b1;
            rd_data   <= mem_data;
            rd_last_q <= (beat_q == last_q);
            if (beat_q == last_q) begin
              cs_n <= '1;
              oe_n <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              beat_q   <= beat_q + 3'd1;
              mem_addr <= beat_addr(base_q, len_q, beat_q + 3'd1);
              if (refresh_req && !refr_used_q) begin
                refr_used_q <= 1'b1;
                refresh_ack <= 1'b1;
                cs_n        <= '1;
                oe_n        <= 1'b1;
                st          <= ST_REFR;
              end else begin
                cnt_q <= next_lat;
              end
            end
          end
        end
        ST_REFR: begin
          cs_n  <= ~(SEL_ONE << sp_q);
          oe_n  <= 1'b0;
          cnt_q <= next_lat;
          st    <= ST_BEAT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  assert_oe_with_cs_R6: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !(&cs_n));
  assert_refresh_release_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_ack |-> ((&cs_n) && oe_n));
  assert_refresh_single_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_ack |=> !refresh_ack);
  assert_done_after_word_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rd_valid));
  assert_upper_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BEAT && $past(st) == ST_BEAT) |-> $stable(mem_addr[AW-1:3]));
endmodule

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl
  import rom_rd_pkg::*;
#(
  parameter int NSP = 2,
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int SW  = (NSP > 1) ? $clog2(NSP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rom_sel,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_space,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SW-1:0]    req_space,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_len,
  input  logic [DW-1:0]    mem_data,
  input  logic             refresh_req,
  output logic [NSP-1:0]   cs_n,
  output logic             oe_n,
  output logic [AW-1:0]    mem_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             refresh_ack,
  output logic             acc_wide
);
  cfg_t              sel_cfg;
  logic              busy;
  logic              fin;
  logic [SW-1:0]     fin_space;
  logic [TURN_W-1:0] fin_turn;
  logic              space_ok;
  logic              start;

  assign req_ready = !busy && space_ok;
  assign start     = req_valid && req_ready;

  rom_cfg_bank #(.NSP(NSP), .SW(SW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .rom_sel(rom_sel),
    .we    (cfg_we),
    .wsel  (cfg_space),
    .wdata (cfg_t'(cfg_wdata)),
    .rsel  (req_space),
    .rcfg  (sel_cfg)
  );

  rom_turn_timer #(.SW(SW)) u_turn (
    .clk      (clk),
    .rst      (rst),
    .fin      (fin),
    .fin_space(fin_space),
    .fin_turn (fin_turn),
    .start    (start),
    .req_space(req_space),
    .space_ok (space_ok)
  );

  rom_beat_engine #(.NSP(NSP), .SW(SW), .AW(AW), .DW(DW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .cfg_i      (sel_cfg),
    .space_i    (req_space),
    .addr_i     (req_addr),
    .len_i      (req_len),
    .mem_data   (mem_data),
    .refresh_req(refresh_req),
    .busy       (busy),
    .fin        (fin),
    .fin_space  (fin_space),
    .fin_turn   (fin_turn),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .mem_addr   (mem_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .done       (done),
    .refresh_ack(refresh_ack),
    .acc_wide   (acc_wide)
  );
endmodule

// File: tb/rom_read_ctrl_tb.sv
module rom_read_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rom_sel = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_space = '0;
  logic [14:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [0:0]  req_space = '0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [31:0] mem_data;
  logic        refresh_req = 1'b0;
  logic [1:0]  cs_n;
  logic        oe_n;
  logic [23:0] mem_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        done;
  logic        refresh_ack;
  logic        acc_wide;

  rom_read_ctrl u_dut (
    .clk(clk), .rst(rst), .rom_sel(rom_sel), .cfg_we(cfg_we),
    .cfg_space(cfg_space), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_space(req_space), .req_addr(req_addr),
    .req_len(req_len), .mem_data(mem_data), .refresh_req(refresh_req),
    .cs_n(cs_n), .oe_n(oe_n), .mem_addr(mem_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .refresh_ack(refresh_ack),
    .acc_wide(acc_wide)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] dev_word(input logic [23:0] a);
    return {8'h5C, a ^ 24'h3C3C3C};
  endfunction
  assign mem_data = dev_word(mem_addr);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0;
  int fails = 0;
  int mism = 0;
  bit finished = 0;

  typedef struct {
    int          cyc;
    logic [31:0] data;
    bit          last;
    string       tag;
  } item_t;
  item_t exp_q[$];

  logic [14:0] sh [2];
  int exp_done = -1000;
  int win_a = -1000, win_e = -1000, win_sp = 0, refr_c = -1000;
  int prev_e = 0, prev_sp = 0, prev_t = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input bit w, input bit b, input int t,
                                     input int n, input int f);
    return {w, b, t[2:0], n[4:0], f[4:0]};
  endfunction

  // monitor: scoreboard pops and per-cycle strobe windows
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        bit in_win;
        logic [1:0] exp_cs;
        if (rd_valid) begin
          if (exp_q.size() == 0) begin
            check("R2", "unexpected word", 1, 0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(it.tag, "word cycle", cyc, it.cyc);
            check(it.tag, "word data", rd_data, it.data);
            if (it.last) exp_done = cyc + 1;
          end
        end
        if (done) check("R7", "done cycle", cyc, exp_done);
        else if (cyc == exp_done) begin
          mism++;
          $display("  done missing at cycle %0d", cyc);
        end
        in_win = (cyc >= win_a) && (cyc < win_e) && (cyc != refr_c);
        exp_cs = in_win ? ~(2'b01 << win_sp) : 2'b11;
        if (cs_n != exp_cs || oe_n != !in_win) begin
          mism++;
          $display("  select mismatch at cycle %0d: cs_n=%b oe_n=%b", cyc, cs_n, oe_n);
        end
        if (refresh_ack != (cyc == refr_c)) begin
          mism++;
          $display("  refresh strobe mismatch at cycle %0d", cyc);
        end
      end
    end
  end

  task automatic wr_cfg(input int sp, input logic [14:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_space = sp[0:0]; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    sh[sp] = w;
  endtask

  task automatic do_req(input int sp, input logic [23:0] ad, input logic [1:0] ln,
                        input bit rf, input bit gap, input string tag);
    logic [14:0] c;
    int f, n, t, nb, a, e, d;
    c = sh[sp];
    f = int'(c[4:0]); n = int'(c[9:5]); t = int'(c[12:10]);
    @(negedge clk);
    req_valid = 1'b1; req_space = sp[0:0]; req_addr = ad; req_len = ln;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    a = cyc;
    req_valid = 1'b0;
    refresh_req = rf;
    if (gap) begin
      d = (sp == prev_sp) ? 1 : ((prev_t == 0) ? 1 : 2 * prev_t);
      check((sp == prev_sp) ? "R10" : "R9", "accept cycle", a, prev_e + d);
    end
    check("R11", "width bit", acc_wide, c[14]);
    nb = (ln == 2'd2) ? 8 : ((ln == 2'd1) ? 4 : 1);
    e = a;
    for (int k = 0; k < nb; k++) begin
      item_t it;
      logic [23:0] wa;
      e = e + (((k == 0) || !c[13]) ? f : n) + 1 + ((k == 1 && rf) ? 1 : 0);
      wa = ad;
      if (ln == 2'd2) wa[2:0] = k[2:0];
      else if (ln == 2'd1) wa[1:0] = k[1:0];
      it.cyc = e; it.data = dev_word(wa); it.last = (k == nb - 1); it.tag = tag;
      exp_q.push_back(it);
    end
    win_sp = sp; win_a = a; win_e = e;
    refr_c = (rf && nb > 1) ? a + f + 1 : -1000;
    prev_e = e; prev_sp = sp; prev_t = t;
  endtask

  task automatic settle(input string tag);
    while (exp_q.size() != 0 || cyc <= exp_done) @(negedge clk);
    repeat (2) @(negedge clk);
    refresh_req = 1'b0;
    check(tag, "strobe window mismatches", mism, 0);
    mism = 0;
  endtask

  task automatic do_reset(input bit strap);
    rst = 1'b1;
    rom_sel = strap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sh[0] = mk(~strap, 0, 7, 31, 31);
    exp_q.delete();
    exp_done = -1000; win_a = -1000; win_e = -1000; refr_c = -1000;
    @(negedge clk);
    #1;
    check("R1", "idle selects", cs_n, 2'b11);
    check("R1", "idle oe_n", oe_n, 1);
    check("R1", "idle rd_valid", rd_valid, 0);
    check("R1", "idle ready", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    sh[1] = '0;
    do_reset(1'b1);
    wr_cfg(1, mk(1, 1, 2, 1, 3));
    // R1 boot defaults, R3 non-burst 32-cycle beats
    do_req(0, 24'h000123, 2'd1, 0, 0, "R1");
    // R4 burst device, R5 8-word stepping, R9 turnaround 14
    do_req(1, 24'h0ABCDE, 2'd2, 0, 1, "R4");
    // R8 refresh mid-burst, R10 same space
    do_req(1, 24'h000777, 2'd1, 1, 1, "R8");
    wr_cfg(0, mk(0, 0, 0, 9, 2));
    // R3 later field ignored, R9 turnaround 4
    do_req(0, 24'h000100, 2'd1, 0, 1, "R3");
    // R8 no refresh on single word, R9 zero delay gives 1
    do_req(1, 24'h000042, 2'd0, 1, 1, "R8");
    // R5 code 3 reads one word
    do_req(1, 24'h000055, 2'd3, 0, 1, "R5");
    // R8 only one refresh in 8 words
    do_req(1, 24'h00FF08, 2'd2, 1, 1, "R8");
    // R11 write during access has no effect on it, R2 short latency
    do_req(0, 24'h000230, 2'd2, 0, 1, "R2");
    wr_cfg(0, mk(0, 0, 1, 4, 6));
    settle("R6");
    do_req(0, 24'h000999, 2'd0, 0, 0, "R11");
    settle("R8");
    do_reset(1'b0);
    do_req(0, 24'h000010, 2'd0, 0, 0, "R1");
    settle("R6");
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule